// File: doc/BRIEF.md
# Serial Key-Map Readout Port

This block is the host-facing side of a matrix keypad scanner. It shares a single serial output pin between two jobs. While the host leaves the port deselected, the pin shows a level that says whether a latched key map is waiting. While the host selects the port, the pin shifts that key map out one bit per host clock.

The host drives an active-low select and a slow serial clock. Both are asynchronous to the block. They pass through two-flop synchronisers into the system clock domain, and every action is taken on the edges detected there. A frame is one leading dummy bit, then the key bits, then one trailing dummy bit. A new bit is launched on each falling host-clock edge, so the host samples on the rising edge.

When the host deselects, the block tells the scanner through a one-cycle release pulse. A flag beside the pulse says whether the host clocked in every key bit or abandoned the read early. In both cases the scanner drops the latched map and its request. A read started with no request pending returns meaningless bits and produces no release.

Top module: `keymap_readout`

## Requirements
- R1: After reset, `rel_pulse` and `rel_done` are 0 and the port is deselected.
- R2: While the port is deselected, `data_out` equals `req_in`.
- R3: After `sel_n` falls, `data_out` is 0 (the leading dummy bit) before any falling edge of `sclk`. This holds whether `sclk` was high or low when `sel_n` fell.
- R4: After the k-th falling edge of `sclk` in a selected read, `data_out` is key bit k for k = 1..NKEYS. Key bit k is `key_map[k-1]`, a pressed key is 1, and bit index row*6+column in the default 4x6 matrix. After edge NKEYS+1, `data_out` is the trailing dummy 0, and it stays 0 on every further edge until deselect.
- R5: The key map is captured when the port is selected. Changes on `key_map` during a read do not change the bits sent.
- R6: A read is complete once a rising `sclk` edge follows the NKEYS-th falling edge. Deselecting after a complete read, with a request pending at select time, gives `rel_pulse` for one clock with `rel_done` = 1.
- R7: Deselecting before the read is complete, with a request pending at select time, gives `rel_pulse` for one clock with `rel_done` = 0.
- R8: A read started while `req_in` is 0 gives no `rel_pulse` at deselect. Afterwards `data_out` again follows `req_in`.
- R9: `rel_pulse` is never high on two consecutive clocks, and `rel_done` is high only together with `rel_pulse`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the `sclk` rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Host select, active low, asynchronous |
| sclk | input | 1 | Host serial clock, asynchronous |
| key_map | input | NKEYS | Latched key map from the scanner, 1 = pressed |
| req_in | input | 1 | Scanner request: a key map is waiting |
| data_out | output | 1 | Request level while deselected, frame bits while selected |
| rel_pulse | output | 1 | One-clock release to the scanner on deselect after a requested read |
| rel_done | output | 1 | With `rel_pulse`: 1 if all key bits were read, 0 if the read was aborted |

## Verification
The assertions assume that `sel_n` and `sclk` never change in the same system clock. They also assume that each level lasts long enough for the synchronisers to see it, so that no edge is lost and the frame index only moves on a detected `sclk` fall. The bench keeps every host-pin level for eight system clocks. It never toggles select and serial clock together, and it raises `sclk` before deselecting. Every sample is taken well after the three-clock synchroniser and edge-detect latency.

// File: rtl/keymap_readout.sv
module keymap_readout #(
  parameter int NKEYS = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             sclk,
  input  logic [NKEYS-1:0] key_map,
  input  logic             req_in,
  output logic             data_out,
  output logic             rel_pulse,
  output logic             rel_done
);
  localparam int HOLD = NKEYS + 2;
  localparam int IW   = $clog2(HOLD + 1);
  localparam int KW   = $clog2(NKEYS);

  logic [2:0] sel_s, clk_s;
  logic [IW-1:0] idx;
  logic [NKEYS-1:0] snap;
  logic sel, armed, done;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_s <= 3'b111;
      clk_s <= 3'b000;
    end else begin
      sel_s <= {sel_s[1:0], sel_n};
      clk_s <= {clk_s[1:0], sclk};
    end

  wire sel_fall = sel_s[2] & ~sel_s[1];
  wire sel_rise = ~sel_s[2] & sel_s[1];
  wire sck_fall = clk_s[2] & ~clk_s[1];
  wire sck_rise = ~clk_s[2] & clk_s[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel <= 1'b0; armed <= 1'b0; done <= 1'b0;
      idx <= '0; snap <= '0;
      rel_pulse <= 1'b0; rel_done <= 1'b0;
    end else begin
      rel_pulse <= 1'b0;
      rel_done  <= 1'b0;
      if (sel_fall) begin
        sel   <= 1'b1;
        armed <= req_in;
        done  <= 1'b0;
        idx   <= '0;
        snap  <= key_map;
      end else if (sel_rise) begin
        sel       <= 1'b0;
        rel_pulse <= sel & armed;
        rel_done  <= sel & armed & done;
        armed     <= 1'b0;
      end else if (sel) begin
        if (sck_fall && idx < IW'(HOLD)) idx <= idx + 1'b1;
        if (sck_rise && idx >= IW'(NKEYS)) done <= 1'b1;
      end
    end

  wire [KW-1:0] pos = KW'(idx - 1'b1);
  wire in_keys = (idx >= IW'(1)) && (idx <= IW'(NKEYS));
  assign data_out = sel ? (in_keys & snap[pos]) : req_in;

  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rel_pulse |=> !rel_pulse);
  assert_done_with_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rel_done |-> rel_pulse);
  assert_pulse_on_deselect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rel_pulse |-> ($past(sel) && !sel));
  assert_done_only_selected_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> sel);
  assert_index_moves_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && $past(sel) && !$past(sel_fall) && !$past(sck_fall)) |-> $stable(idx));
  assert_index_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IW'(HOLD));
endmodule

// File: tb/keymap_readout_tb.sv
module keymap_readout_tb_top;
  localparam int CLK_NS = 10;
  localparam int HP = 8;
  localparam int NK = 24;

  logic clk = 0, rst_n = 0, sel_n = 1, sclk = 0, req_in = 0;
  logic [NK-1:0] key_map = '0;
  logic data_out, rel_pulse, rel_done;
  int checks = 0, failures = 0, pulses = 0;
  logic last_done = 0;

  keymap_readout #(.NKEYS(NK)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .key_map(key_map),
    .req_in(req_in), .data_out(data_out), .rel_pulse(rel_pulse), .rel_done(rel_done));

  always #(CLK_NS/2) clk = ~clk;

  always @(negedge clk) if (rel_pulse) begin pulses++; last_done = rel_done; end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic hold(); repeat (HP) @(negedge clk); endtask

  task automatic t_reset();
    rst_n = 0; repeat (4) @(negedge clk);
    chk("R1 rel_pulse", rel_pulse, 1'b0);
    chk("R1 rel_done", rel_done, 1'b0);
    rst_n = 1; hold();
    chk("R1 deselected data", data_out, 1'b0);
  endtask

  task automatic t_request_level();
    req_in = 1; hold(); chk("R2 data=req 1", data_out, 1'b1);
    req_in = 0; hold(); chk("R2 data=req 0", data_out, 1'b0);
  endtask

  task automatic t_full_read(input logic [NK-1:0] km, input logic sck_hi, input logic scramble);
    int p0;
    key_map = km; req_in = 1; sclk = sck_hi; hold();
    p0 = pulses;
    sel_n = 0; hold();
    chk("R3 leading dummy", data_out, 1'b0);
    if (scramble) key_map = ~km;
    for (int k = 1; k <= NK + 2; k++) begin
      if (sclk == 1'b0) begin sclk = 1; hold(); end
      sclk = 0; hold();
      if (k <= NK) chk(scramble ? "R5 captured bit" : "R4 key bit", data_out, km[k-1]);
      else chk("R4 trailing low", data_out, 1'b0);
    end
    sclk = 1; hold();
    sel_n = 1; hold();
    chk("R6 one release", pulses == p0 + 1, 1'b1);
    chk("R6 done flag", last_done, 1'b1);
    req_in = 0; hold();
    chk("R2 after release", data_out, 1'b0);
  endtask

  task automatic t_abort();
    int p0;
    key_map = 24'hA5A5A5; req_in = 1; sclk = 0; hold();
    p0 = pulses;
    sel_n = 0; hold();
    for (int k = 1; k <= 10; k++) begin sclk = 1; hold(); sclk = 0; hold(); end
    chk("R4 mid bit10", data_out, key_map[9]);
    sclk = 1; hold();
    sel_n = 1; hold();
    chk("R7 one release", pulses == p0 + 1, 1'b1);
    chk("R7 aborted flag", last_done, 1'b0);
    req_in = 0; hold();
  endtask

  task automatic t_no_request();
    int p0;
    req_in = 0; key_map = 24'hFFFFFF; sclk = 0; hold();
    p0 = pulses;
    sel_n = 0; hold();
    for (int k = 1; k <= 30; k++) begin sclk = 1; hold(); sclk = 0; hold(); end
    sclk = 1; hold();
    sel_n = 1; hold();
    chk("R8 no release", pulses == p0, 1'b1);
    chk("R8 data follows req 0", data_out, 1'b0);
    req_in = 1; hold();
    chk("R8 data follows req 1", data_out, 1'b1);
    req_in = 0; hold();
  endtask

  initial begin
    t_reset();
    t_request_level();
    t_full_read(24'h000001, 1'b0, 1'b0);
    t_full_read(24'h800000, 1'b1, 1'b0);
    t_full_read(24'h3C96E1, 1'b1, 1'b1);
    t_abort();
    t_no_request();
    t_full_read(24'hFFFFFF, 1'b0, 1'b0);
    chk("R9 total releases", pulses == 5, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule